// File: doc/BRIEF.md
# Accumulator Condition Code Generator

This block turns the 56-bit signed result of a DSP data ALU operation into seven registered condition flags. They are limit (L), extension (E), unnormalized (U), negative (N), zero (Z), overflow (V) and carry (C). The datapath supplies the result word, the carry or borrow out of the top bit, an overflow indication and a strobe from the data shifter/limiter. A per-operation update enable marks the cycles whose result should reach the flags. A two-bit scaling mode selects which bits of the result count as its integer part (for E) and which adjacent pair is tested for normalization (for U).

Six of the flags are loaded together when the update enable is high and hold otherwise. The limit flag is sticky. Any overflow on an update, or any limiting event, sets it, and only a user clear brings it back to zero. If a clear and a new limiting event arrive in the same cycle, the event wins. All flags appear one clock edge after the inputs are sampled.

Top module: `acc_ccr_gen`

## Requirements
- R1: While reset is asserted, and until the first active edge after the synchronized release, all seven flags read 0.
- R2: On an edge with `upd_en_i`=1, `flag_n_o` takes bit 55 of `res_i`.
- R3: On an edge with `upd_en_i`=1, `flag_z_o` becomes 1 exactly when all 56 bits of `res_i` are 0.
- R4: On an edge with `upd_en_i`=1, `flag_v_o` takes `ovf_i`; it is not sticky and clears on the next update without overflow.
- R5: On an edge with `upd_en_i`=1, `flag_c_o` takes `carry_i`.
- R6: On an update, `flag_e_o` is 0 when the integer window of `res_i` is all zeros or all ones, and 1 otherwise. The window runs from bit 55 down to bit 47 for `scale_i`=00, down to 48 for 01 and down to 46 for 10.
- R7: On an update, `flag_u_o` is 1 when two adjacent bits of `res_i` are equal. The pair is 47/46 for `scale_i`=00, 48/47 for 01 and 46/45 for 10.
- R8: `scale_i`=11 is reserved and gives the same E and U values as 00.
- R9: On an edge with `upd_en_i`=0, E, U, N, Z, V and C keep their previous values.
- R10: `flag_l_o` is set by an edge where `upd_en_i`=1 and `ovf_i`=1, or by any edge with `lim_evt_i`=1. Once set, it stays set. An overflow with `upd_en_i`=0 does not set it.
- R11: An edge with `lim_clr_i`=1 and no set condition clears `flag_l_o`.
- R12: When `lim_clr_i` and a set condition occur on the same edge, `flag_l_o` ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| res_i | input | 56 | Accumulator result |
| carry_i | input | 1 | Carry/borrow out of bit 55 |
| ovf_i | input | 1 | Arithmetic overflow of the result |
| lim_evt_i | input | 1 | Shifter/limiter performed a limiting operation |
| scale_i | input | 2 | Scaling mode: 00 none, 01 down, 10 up, 11 reserved |
| upd_en_i | input | 1 | Load the arithmetic flags this cycle |
| lim_clr_i | input | 1 | User clear of the limit flag |
| flag_l_o | output | 1 | Sticky limit flag |
| flag_e_o | output | 1 | Extension flag |
| flag_u_o | output | 1 | Unnormalized flag |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Each flag is due exactly one rising edge after its inputs are sampled, including the sticky limit flag, which has the same single register stage. The bench drives inputs on the falling edge and lets one rising edge pass. It compares all seven outputs on the following falling edge against a bench model advanced for that same edge. After reset is released, the bench waits out the two-stage reset synchronizer before it applies the first update.

// File: rtl/accg_pkg.sv
package accg_pkg;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  typedef struct packed {
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;

endpackage

// File: rtl/accg_rst_sync.sv
module accg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/accg_window.sv
module accg_window
  import accg_pkg::*;
#(
  parameter int ACC_W  = 56,
  parameter int INT_LO = 47
) (
  input  logic [ACC_W-1:0] res,
  input  logic [1:0]       scale,
  output logic             ext,
  output logic             unnorm
);

  localparam int N_VAR = 3;

  logic [N_VAR-1:0] ext_v;
  logic [N_VAR-1:0] unn_v;

  // variant 0: no scaling, 1: window one bit higher, 2: one bit lower
  for (genvar g = 0; g < N_VAR; g++) begin : g_var
    localparam int LO   = INT_LO + ((g == 1) ? 1 : 0) - ((g == 2) ? 1 : 0);
    localparam int SPAN = ACC_W - LO;
    logic [SPAN-1:0] win;
    assign win      = res[ACC_W-1:LO];
    assign ext_v[g] = ~((&win) | ~(|win));
    assign unn_v[g] = ~(res[LO] ^ res[LO-1]);
  end

  always_comb begin
    unique case (scale_e'(scale))
      SCL_DOWN: begin
        ext    = ext_v[1];
        unnorm = unn_v[1];
      end
      SCL_UP: begin
        ext    = ext_v[2];
        unnorm = unn_v[2];
      end
      default: begin
        ext    = ext_v[0];
        unnorm = unn_v[0];
      end
    endcase
  end

endmodule

// File: rtl/accg_limit.sv
module accg_limit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic lim_q
);

  logic lim_d;

  always_comb begin
    lim_d = lim_q;
    if (set_i) begin
      lim_d = 1'b1;
    end else if (clr_i) begin
      lim_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= 1'b0;
    end else begin
      lim_q <= lim_d;
    end
  end

endmodule

// File: rtl/acc_ccr_gen.sv
module acc_ccr_gen
  import accg_pkg::*;
#(
  parameter int ACC_W      = 56,
  parameter int INT_LO     = 47,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] res_i,
  input  logic             carry_i,
  input  logic             ovf_i,
  input  logic             lim_evt_i,
  input  logic [1:0]       scale_i,
  input  logic             upd_en_i,
  input  logic             lim_clr_i,
  output logic             flag_l_o,
  output logic             flag_e_o,
  output logic             flag_u_o,
  output logic             flag_n_o,
  output logic             flag_z_o,
  output logic             flag_v_o,
  output logic             flag_c_o
);

  logic         rst_sync_n;
  logic         ext_w;
  logic         unn_w;
  logic         lim_set;
  arith_flags_t ar_d;
  arith_flags_t ar_q;

  accg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  accg_window #(.ACC_W(ACC_W), .INT_LO(INT_LO)) u_win (
    .res    (res_i),
    .scale  (scale_i),
    .ext    (ext_w),
    .unnorm (unn_w)
  );

  // next state of the arithmetic flags, enable written out
  always_comb begin
    ar_d = ar_q;
    if (upd_en_i) begin
      ar_d.e = ext_w;
      ar_d.u = unn_w;
      ar_d.n = res_i[ACC_W-1];
      ar_d.z = ~(|res_i);
      ar_d.v = ovf_i;
      ar_d.c = carry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ar_q <= '0;
    end else begin
      ar_q <= ar_d;
    end
  end

  assign lim_set = (upd_en_i & ovf_i) | lim_evt_i;

  accg_limit u_lim (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (lim_set),
    .clr_i (lim_clr_i),
    .lim_q (flag_l_o)
  );

  assign flag_e_o = ar_q.e;
  assign flag_u_o = ar_q.u;
  assign flag_n_o = ar_q.n;
  assign flag_z_o = ar_q.z;
  assign flag_v_o = ar_q.v;
  assign flag_c_o = ar_q.c;

endmodule

// File: rtl/accg_chk.sv
module accg_chk #(
  parameter int ACC_W  = 56,
  parameter int INT_LO = 47
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] res_i,
  input logic             carry_i,
  input logic             ovf_i,
  input logic             lim_evt_i,
  input logic [1:0]       scale_i,
  input logic             upd_en_i,
  input logic             lim_clr_i,
  input logic             flag_l_o,
  input logic             flag_e_o,
  input logic             flag_u_o,
  input logic             flag_n_o,
  input logic             flag_z_o,
  input logic             flag_v_o,
  input logic             flag_c_o
);

  p_neg_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flag_n_o == $past(res_i[ACC_W-1]));

  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flag_z_o == ($past(res_i) == '0));

  p_ovf_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flag_v_o == $past(ovf_i));

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> flag_c_o == $past(carry_i));

  p_rsvd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && scale_i == 2'b11 && res_i[ACC_W-1:INT_LO] == '0) |=> !flag_e_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en_i |=> $stable({flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o}));

  p_lim_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_evt_i || (upd_en_i && ovf_i)) |=> flag_l_o);

  p_lim_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_l_o && !lim_clr_i) |=> flag_l_o);

  p_lim_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_clr_i && !lim_evt_i && !(upd_en_i && ovf_i)) |=> !flag_l_o);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_clr_i && lim_evt_i) |=> flag_l_o);

endmodule

bind acc_ccr_gen accg_chk #(.ACC_W(ACC_W), .INT_LO(INT_LO)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .res_i     (res_i),
  .carry_i   (carry_i),
  .ovf_i     (ovf_i),
  .lim_evt_i (lim_evt_i),
  .scale_i   (scale_i),
  .upd_en_i  (upd_en_i),
  .lim_clr_i (lim_clr_i),
  .flag_l_o  (flag_l_o),
  .flag_e_o  (flag_e_o),
  .flag_u_o  (flag_u_o),
  .flag_n_o  (flag_n_o),
  .flag_z_o  (flag_z_o),
  .flag_v_o  (flag_v_o),
  .flag_c_o  (flag_c_o)
);

// File: tb/acc_ccr_gen_tb_top.sv
`timescale 1ns/1ps
module acc_ccr_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic [55:0] res_i;
  logic        carry_i, ovf_i, lim_evt_i, upd_en_i, lim_clr_i;
  logic [1:0]  scale_i;
  logic        flag_l_o, flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // bench model state
  logic m_l, m_e, m_u, m_n, m_z, m_v, m_c;

  acc_ccr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .res_i(res_i), .carry_i(carry_i), .ovf_i(ovf_i),
    .lim_evt_i(lim_evt_i), .scale_i(scale_i), .upd_en_i(upd_en_i),
    .lim_clr_i(lim_clr_i), .flag_l_o(flag_l_o), .flag_e_o(flag_e_o),
    .flag_u_o(flag_u_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
    .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int win_lo(logic [1:0] s);
    if (s == 2'b01) return 48;
    if (s == 2'b10) return 46;
    return 47;
  endfunction

  function automatic logic f_ext(logic [55:0] r, logic [1:0] s);
    int  lo;
    logic all0;
    logic all1;
    lo = win_lo(s);
    all0 = 1'b1;
    all1 = 1'b1;
    for (int i = lo; i <= 55; i++) begin
      if (r[i]) all0 = 1'b0;
      else      all1 = 1'b0;
    end
    return !(all0 || all1);
  endfunction

  function automatic logic f_unn(logic [55:0] r, logic [1:0] s);
    int lo;
    lo = win_lo(s);
    return r[lo] == r[lo-1];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  // drive at falling edge, pass one rising edge, compare at next falling edge
  task automatic step(input logic [55:0] r, input logic c, input logic v,
                      input logic le, input logic [1:0] s, input logic u,
                      input logic clr);
    res_i = r; carry_i = c; ovf_i = v; lim_evt_i = le;
    scale_i = s; upd_en_i = u; lim_clr_i = clr;
    @(posedge clk);
    if (u) begin
      m_e = f_ext(r, s);
      m_u = f_unn(r, s);
      m_n = r[55];
      m_z = (r == 56'd0);
      m_v = v;
      m_c = c;
    end
    if ((u && v) || le) m_l = 1'b1;
    else if (clr)       m_l = 1'b0;
    @(negedge clk);
    chk("R10 L", flag_l_o, m_l);
    chk("R6 E",  flag_e_o, m_e);
    chk("R7 U",  flag_u_o, m_u);
    chk("R2 N",  flag_n_o, m_n);
    chk("R3 Z",  flag_z_o, m_z);
    chk("R4 V",  flag_v_o, m_v);
    chk("R5 C",  flag_c_o, m_c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [55:0] r;
    void'($urandom(32'd4711));
    m_l = 0; m_e = 0; m_u = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    rst_n = 1'b0;
    res_i = 56'h80_123456_789ABC; carry_i = 1; ovf_i = 1; lim_evt_i = 1;
    scale_i = 2'b00; upd_en_i = 1; lim_clr_i = 0;
    repeat (3) @(negedge clk);
    // R1: flags held at zero during reset despite active inputs
    chk("R1 reset L", flag_l_o, 1'b0);
    chk("R1 reset E", flag_e_o, 1'b0);
    chk("R1 reset N", flag_n_o, 1'b0);
    chk("R1 reset V", flag_v_o, 1'b0);
    chk("R1 reset C", flag_c_o, 1'b0);
    upd_en_i = 0; ovf_i = 0; lim_evt_i = 0; carry_i = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release Z", flag_z_o, 1'b0);
    chk("R1 after release L", flag_l_o, 1'b0);

    // R6: example value, no scaling -> E set; scale down -> E clear
    step(56'h00_800000_000000, 0, 0, 0, 2'b00, 1, 0);
    chk("R6 example E", flag_e_o, 1'b1);
    chk("R7 example U", flag_u_o, 1'b0);
    step(56'h00_800000_000000, 0, 0, 0, 2'b01, 1, 0);
    chk("R6 scale down E", flag_e_o, 1'b0);
    step(56'hFF_400000_000000, 0, 0, 0, 2'b10, 1, 0);
    chk("R6 scale up E", flag_e_o, 1'b1);
    // R8: reserved mode behaves as no scaling
    step(56'h00_800000_000000, 0, 0, 0, 2'b11, 1, 0);
    chk("R8 rsvd E", flag_e_o, 1'b1);
    step(56'hFF_C00000_000000, 1, 0, 0, 2'b11, 1, 0);
    chk("R8 rsvd E ones", flag_e_o, 1'b0);
    chk("R8 rsvd U", flag_u_o, 1'b1);
    // R3: zero result
    step(56'd0, 0, 0, 0, 2'b00, 1, 0);
    chk("R3 zero", flag_z_o, 1'b1);
    // R9: no update, flags hold
    step(56'h80_000000_000001, 1, 1, 0, 2'b10, 0, 0);
    chk("R9 hold Z", flag_z_o, 1'b1);
    chk("R9 hold N", flag_n_o, 1'b0);
    chk("R10 ovf without update leaves L", flag_l_o, 1'b0);
    // R10/R4: overflow sets L, V clears on next update, L stays
    step(56'h7F_000000_000000, 0, 1, 0, 2'b00, 1, 0);
    chk("R10 L set by ovf", flag_l_o, 1'b1);
    step(56'h01_000000_000000, 0, 0, 0, 2'b00, 1, 0);
    chk("R4 V not sticky", flag_v_o, 1'b0);
    chk("R10 L sticky", flag_l_o, 1'b1);
    // R11: user clear
    step(56'h01_000000_000000, 0, 0, 0, 2'b00, 0, 1);
    chk("R11 clear", flag_l_o, 1'b0);
    // R12: event and clear together
    step(56'h01_000000_000000, 0, 0, 1, 2'b00, 0, 1);
    chk("R12 set wins", flag_l_o, 1'b1);
    step(56'h01_000000_000000, 0, 1, 0, 2'b00, 1, 1);
    chk("R12 ovf set wins", flag_l_o, 1'b1);

    for (int k = 0; k < 800; k++) begin
      r = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: r = {{10{r[45]}}, r[45:0]};
        1: r = {{9{r[46]}}, r[46:0]};
        2: r = {{8{r[47]}}, r[47:0]};
        default: ;
      endcase
      if ($urandom_range(0, 31) == 0) r = 56'd0;
      step(r, 1'($urandom), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 15) == 0), 2'($urandom),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule